// File: doc/BRIEF.md
# Packed SIMD Rounding Average Unit

This block averages two 64-bit operands lane by lane. The operands are treated as a row of equal unsigned lanes of 8, 16, 32 or 64 bits, and each result lane is the mean of the matching source lanes, rounded up when the sum is odd. A single lane-size code governs both sources and the result.

A mode input selects between two forms. In packed form every lane is computed. In scalar form only the lowest lane is computed, and every bit above that lane is taken unchanged from the current destination value, which is supplied on its own input. The result is registered. A one-cycle done flag marks each new result.

Top module: `pkd_rnd_avg`

## Requirements
- R1: With lane code 2'b00, each of the eight 8-bit lanes of the result is (a + b + 1) >> 1 of the matching source lanes. Lane i occupies bits [8i+7:8i], and lane 0 is least significant.
- R2: With lane code 2'b01, each of the four 16-bit lanes of the result is (a + b + 1) >> 1, with lane i at bits [16i+15:16i].
- R3: With lane code 2'b10, each of the two 32-bit lanes of the result is (a + b + 1) >> 1, with lane i at bits [32i+31:32i].
- R4: With lane code 2'b11, the single 64-bit result is (a + b + 1) >> 1 computed without loss of the carry. For example, two all-ones operands give all ones.
- R5: When scalar_only is 1, only lane 0 of the selected width is averaged. Result bits above that lane equal dst_old as sampled with the strobe. When the lane code is 2'b11, the whole word is averaged.
- R6: res_q and done_q update on the rising clock edge at which in_valid is 1. done_q is 1 for exactly the cycle after each strobe and 0 otherwise.
- R7: While in_valid is 0, res_q holds its value, regardless of the operand inputs.
- R8: Asserting rst_n low clears res_q to zero and done_q to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Strobe: compute and register a result this edge |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand |
| dst_old | input | 64 | Current destination value, merged in scalar form |
| lane_sz | input | 2 | Lane width: 00=8, 01=16, 10=32, 11=64 bits |
| scalar_only | input | 1 | 1 = lowest lane only, 0 = all lanes |
| res_q | output | 64 | Registered result |
| done_q | output | 1 | One-cycle flag for a new result |

## Verification
The assertions assume that in_valid, lane_sz, scalar_only and the three data words are known and stable around each rising edge. They also assume that reset is released away from an edge. The bench changes every input only at the falling edge and holds it through the following rising edge. It keeps the lane code inside its two-bit range. It deliberately changes the operands while in_valid is low, so that the hold property is tested against moving inputs.

// File: rtl/avg_pkg.sv
package avg_pkg;
  localparam int unsigned WORD_W = 64;
  localparam int unsigned NUM_SZ = 4;

  typedef enum logic [1:0] {
    LS_B8  = 2'b00,
    LS_B16 = 2'b01,
    LS_B32 = 2'b10,
    LS_B64 = 2'b11
  } lane_sz_e;

  // Mask of lane 0 for a given lane width code.
  function automatic logic [WORD_W-1:0] low_lane_mask(lane_sz_e sz);
    logic [WORD_W-1:0] m;
    case (sz)
      LS_B8:   m = {{(WORD_W-8){1'b0}},  {8{1'b1}}};
      LS_B16:  m = {{(WORD_W-16){1'b0}}, {16{1'b1}}};
      LS_B32:  m = {{(WORD_W-32){1'b0}}, {32{1'b1}}};
      default: m = {WORD_W{1'b1}};
    endcase
    return m;
  endfunction
endpackage

// File: rtl/avg_lane.sv
module avg_lane #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  localparam int unsigned SUM_W = W + 1;

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum = {1'b0, a} + {1'b0, b} + SUM_W'(1);
    y   = sum[SUM_W-1:1];
  end

  // Lane average must lie between the two operands (R1..R4).
  always_comb begin
    p_avg_between_r1: assert (((y >= a) && (y <= b)) || ((y >= b) && (y <= a)))
      else $error("lane average outside operand range");
  end
endmodule

// File: rtl/avg_packed.sv
module avg_packed #(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned W      = 8
) (
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  output logic [WORD_W-1:0] y
);
  localparam int unsigned LANES = WORD_W / W;

  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    avg_lane #(.W(W)) u_lane (
      .a (a[gi*W +: W]),
      .b (b[gi*W +: W]),
      .y (y[gi*W +: W])
    );
  end
endmodule

// File: rtl/avg_merge.sv
module avg_merge
  import avg_pkg::*;
(
  input  logic [WORD_W-1:0] pk [NUM_SZ],
  input  lane_sz_e          sz,
  input  logic              scalar_only,
  input  logic [WORD_W-1:0] dst_old,
  output logic [WORD_W-1:0] y
);
  logic [WORD_W-1:0] sel;
  logic [WORD_W-1:0] keep_mask;

  always_comb begin
    sel       = pk[sz];
    keep_mask = scalar_only ? ~low_lane_mask(sz) : '0;
    y         = (sel & ~keep_mask) | (dst_old & keep_mask);
  end
endmodule

// File: rtl/pkd_rnd_avg.sv
module pkd_rnd_avg
  import avg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] src_a,
  input  logic [63:0] src_b,
  input  logic [63:0] dst_old,
  input  logic [1:0]  lane_sz,
  input  logic        scalar_only,
  output logic [63:0] res_q,
  output logic        done_q
);
  logic [WORD_W-1:0] pk [NUM_SZ];
  logic [WORD_W-1:0] merged;
  logic [WORD_W-1:0] res_d;
  logic              done_d;

  for (genvar gs = 0; gs < NUM_SZ; gs++) begin : g_size
    localparam int unsigned LW = 8 << gs;
    avg_packed #(.WORD_W(WORD_W), .W(LW)) u_pk (
      .a (src_a),
      .b (src_b),
      .y (pk[gs])
    );
  end

  avg_merge u_merge (
    .pk          (pk),
    .sz          (lane_sz_e'(lane_sz)),
    .scalar_only (scalar_only),
    .dst_old     (dst_old),
    .y           (merged)
  );

  // Next-state
  always_comb begin
    res_d  = in_valid ? merged : res_q;
    done_d = in_valid;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      res_q  <= res_d;
      done_q <= done_d;
    end
  end

  p_done_after_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> done_q);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !done_q);
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(res_q));
  p_scalar_upper8_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && scalar_only && lane_sz == 2'b00) |=> (res_q[63:8] == $past(dst_old[63:8])));
  p_scalar_upper32_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && scalar_only && lane_sz == 2'b10) |=> (res_q[63:32] == $past(dst_old[63:32])));
endmodule

// File: tb/tb_pkd_rnd_avg.sv
module tb_pkd_rnd_avg;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] src_a, src_b, dst_old;
  logic [1:0]  lane_sz;
  logic        scalar_only;
  logic [63:0] res_q;
  logic        done_q;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2ns clk = ~clk;

  pkd_rnd_avg dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .src_a(src_a), .src_b(src_b), .dst_old(dst_old),
    .lane_sz(lane_sz), .scalar_only(scalar_only),
    .res_q(res_q), .done_q(done_q)
  );

  function automatic logic [63:0] ref_avg(logic [63:0] a, logic [63:0] b,
                                          logic [63:0] d, logic [1:0] sz, logic sc);
    int w = 8 << sz;
    int n = sc ? 1 : 64 / w;
    logic [63:0] r = d;
    for (int i = 0; i < n; i++) begin
      logic [64:0] la = 0, lb = 0, s;
      for (int k = 0; k < w; k++) begin
        la[k] = a[i*w+k];
        lb[k] = b[i*w+k];
      end
      s = (la + lb + 65'd1) >> 1;
      for (int k = 0; k < w; k++) r[i*w+k] = s[k];
    end
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(logic [1:0] sz, logic sc);
    if (sc) return "R5";
    case (sz)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic run_op(logic [63:0] a, logic [63:0] b, logic [63:0] d,
                        logic [1:0] sz, logic sc);
    logic [63:0] exp = ref_avg(a, b, d, sz, sc);
    @(negedge clk);
    src_a = a; src_b = b; dst_old = d; lane_sz = sz; scalar_only = sc;
    in_valid = 1'b1;
    @(negedge clk);
    check(tag_of(sz, sc), res_q, exp);
    check("R6", {63'd0, done_q}, 64'd1);
    in_valid = 1'b0;
    src_a = ~a; src_b = {b[31:0], b[63:32]}; dst_old = ~d;
    @(negedge clk);
    check("R6", {63'd0, done_q}, 64'd0);
    check("R7", res_q, exp);
  endtask

  initial begin
    #(4ns * 200000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0417));
    in_valid = 0; src_a = '1; src_b = '1; dst_old = '1; lane_sz = 0; scalar_only = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R8", res_q, 64'd0);
    check("R8", {63'd0, done_q}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8", res_q, 64'd0);

    // Directed corners for each size and mode
    for (int s = 0; s < 4; s++) begin
      for (int m = 0; m < 2; m++) begin
        run_op('1, '1, 64'h0123_4567_89AB_CDEF, 2'(s), 1'(m));
        run_op('0, '0, 64'hFEDC_BA98_7654_3210, 2'(s), 1'(m));
        run_op('1, '0, 64'hA5A5_5A5A_A5A5_5A5A, 2'(s), 1'(m));
        run_op(64'h0101_0101_0101_0101, 64'h0202_0202_0202_0202, '1, 2'(s), 1'(m));
      end
    end
    // R4: top-bit carry kept
    run_op(64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFF, '0, 2'b11, 1'b0);
    // R1: odd sum rounds up: 0x01 and 0x02 -> 0x02
    run_op(64'h0000_0000_0000_0001, 64'h0000_0000_0000_0002, '0, 2'b00, 1'b0);

    // Random
    for (int i = 0; i < 400; i++) begin
      run_op({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
             2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
    end

    // R8: reset mid-run clears the registered result
    run_op('1, 64'h1, '0, 2'b00, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    #1ns;
    check("R8", res_q, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule